// File: doc/BRIEF.md
# Clocked Reset Supervisor with Watchdog

This block generates the active-low reset for a clocked domain. Three independent causes pull the reset low: a synchronous supply-fault flag from an analog monitor, a manual reset input held low, and a watchdog that times out when its strobe input stops changing. When every cause has cleared, the reset stays asserted for a fixed number of clock cycles and then releases. The block asserts its own reset output at power-on and applies the same hold-off before the first release.

The manual input and the watchdog strobe are asynchronous, so each one passes through a two-flop synchroniser. Manual-reset lows shorter than a rejection window are ignored. The watchdog counter is held at zero while reset is asserted. Either edge on the strobe clears the counter. When the strobe driver is reported floating, the watchdog clears itself at seven eighths of its period and never expires. A three-bit cause vector reports which source started the most recent reset.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `reset_n_o` is low and `cause_o` is 3'b000. After `rst_n` rises, `reset_n_o` stays low for exactly RST_TIMEOUT cycles, provided no cause is present.
- R2: A high `supply_fault_i` sampled at a clock edge drives `reset_n_o` low at that edge. The output releases RST_TIMEOUT cycles after the last edge that saw the fault.
- R3: A low on `mrst_n_i` that lasts at least MR_GLITCH cycles after synchronisation asserts reset. After the input returns high, `reset_n_o` stays low for RST_TIMEOUT+3 cycles: two synchroniser stages, one filter stage, then the hold-off.
- R4: A low pulse on `mrst_n_i` shorter than MR_GLITCH cycles has no effect on `reset_n_o`.
- R5: After a release with `wd_float_i` low and no strobe edges, `reset_n_o` stays high for exactly WD_TIMEOUT cycles. It then goes low for exactly RST_TIMEOUT cycles.
- R6: A rising or falling edge on `wd_strobe_i` clears the watchdog. A single-cycle pulse counts as a valid activity. Strobe activity at intervals shorter than WD_TIMEOUT keeps `reset_n_o` high.
- R7: The watchdog counter is zero in every cycle that follows a cycle with reset asserted, so counting starts from zero at release.
- R8: While `wd_float_i` is high, the watchdog never expires. Its counter restarts once it reaches (7*WD_TIMEOUT)/8 cycles.
- R9: `cause_o` bit 0 means supply fault, bit 1 means manual reset and bit 2 means watchdog expiry. The vector is loaded with the active causes when a reset begins and ORs in further causes while reset is held. It stays stable while reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| supply_fault_i | input | 1 | Supply-fault flag, synchronous to clk, active high |
| mrst_n_i | input | 1 | Manual reset request, asynchronous, active low |
| wd_strobe_i | input | 1 | Watchdog activity strobe, asynchronous |
| wd_float_i | input | 1 | Strobe driver is high-impedance, synchronous |
| reset_n_o | output | 1 | Supervised reset, active low |
| cause_o | output | 3 | Source of the latest reset: {watchdog, manual, supply} |

## Verification
The release delay is the main signal of internal health. A hold counter that does not clear, or a cause that is lost, shows as a release that is too early or too late by a countable number of cycles within one RST_TIMEOUT window. A watchdog counter that is not held during reset shows as a high time after release that is not exactly WD_TIMEOUT. A filter or edge detector that is wrong shows within a few cycles in one of two ways: a short manual pulse that causes a reset, or strobe activity that fails to keep reset high. A wrong cause latch shows in `cause_o` as soon as the reset releases.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef struct packed {
    logic wdog;
    logic manual;
    logic supply;
  } sup_cause_t;

  localparam int unsigned CAUSE_W = $bits(sup_cause_t);

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter int unsigned  WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    logic stage1_q, stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q <= RST_VAL[gi];
        stage2_q <= RST_VAL[gi];
      end else begin
        stage1_q <= d_i[gi];
        stage2_q <= stage1_q;
      end
    end

    assign q_o[gi] = stage2_q;
  end

endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
  parameter int unsigned MR_GLITCH = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_sync_i,
  output logic mr_active_o
);

  localparam int unsigned CNT_W   = (MR_GLITCH > 1) ? $clog2(MR_GLITCH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MR_GLITCH - 1);

  logic [CNT_W-1:0] low_cnt_q, low_cnt_d;
  logic             active_q, active_d;
  logic             cnt_en;

  always_comb begin
    low_cnt_d = low_cnt_q;
    active_d  = active_q;
    cnt_en    = 1'b0;
    if (mr_n_sync_i) begin
      low_cnt_d = '0;
      active_d  = 1'b0;
      cnt_en    = 1'b1;
    end else if (!active_q) begin
      cnt_en = 1'b1;
      if (low_cnt_q == CNT_LAST) begin
        active_d = 1'b1;
      end else begin
        low_cnt_d = low_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      active_q  <= 1'b0;
    end else if (cnt_en) begin
      low_cnt_q <= low_cnt_d;
      active_q  <= active_d;
    end
  end

  assign mr_active_o = active_q;

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned WD_TIMEOUT = 4000,
  localparam int unsigned CNT_W = (WD_TIMEOUT > 1) ? $clog2(WD_TIMEOUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_sync_i,
  input  logic             float_i,
  input  logic             hold_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int unsigned FLOAT_LIM = (WD_TIMEOUT * 7) / 8;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(WD_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] FLOAT_TOP = CNT_W'((FLOAT_LIM > 0) ? FLOAT_LIM - 1 : 0);

  logic             strobe_prev_q;
  logic             strobe_edge;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             expire;

  assign strobe_edge = strobe_sync_i ^ strobe_prev_q;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    expire = 1'b0;
    if (hold_i || strobe_edge) begin
      cnt_d = '0;
    end else if (float_i && (cnt_q >= FLOAT_TOP)) begin
      cnt_d = '0;
    end else if (!float_i && (cnt_q == CNT_LAST)) begin
      cnt_d  = '0;
      expire = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev_q <= 1'b0;
      cnt_q         <= '0;
    end else begin
      strobe_prev_q <= strobe_sync_i;
      cnt_q         <= cnt_d;
    end
  end

  assign expire_o = expire;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer
  import sup_pkg::*;
#(
  parameter int unsigned RST_TIMEOUT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sup_cause_t cause_i,
  output logic       asserted_o,
  output sup_cause_t cause_o
);

  localparam int unsigned CNT_W = (RST_TIMEOUT > 1) ? $clog2(RST_TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             asserted_q, asserted_d;
  sup_cause_t       cause_q, cause_d;
  logic             any_cause;
  logic             upd_en;

  assign any_cause = |cause_i;

  always_comb begin
    cnt_d      = cnt_q;
    asserted_d = asserted_q;
    cause_d    = cause_q;
    upd_en     = 1'b0;
    if (any_cause) begin
      upd_en     = 1'b1;
      cnt_d      = '0;
      asserted_d = 1'b1;
      cause_d    = asserted_q ? (cause_q | cause_i) : cause_i;
    end else if (asserted_q) begin
      upd_en = 1'b1;
      if (cnt_q == CNT_LAST) begin
        asserted_d = 1'b0;
        cnt_d      = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      asserted_q <= 1'b1;
      cause_q    <= '0;
    end else if (upd_en) begin
      cnt_q      <= cnt_d;
      asserted_q <= asserted_d;
      cause_q    <= cause_d;
    end
  end

  assign asserted_o = asserted_q;
  assign cause_o    = cause_q;

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
#(
  parameter int unsigned RST_TIMEOUT = 1000,
  parameter int unsigned WD_TIMEOUT  = 4000,
  parameter int unsigned MR_GLITCH   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_fault_i,
  input  logic       mrst_n_i,
  input  logic       wd_strobe_i,
  input  logic       wd_float_i,
  output logic       reset_n_o,
  output logic [2:0] cause_o
);

  localparam int unsigned WD_CW = (WD_TIMEOUT > 1) ? $clog2(WD_TIMEOUT) : 1;

  logic [1:0]       async_in, sync_out;
  logic             mr_n_sync, strobe_sync;
  logic             mr_active;
  logic             wd_expire;
  logic [WD_CW-1:0] wd_cnt;
  logic             rst_asserted;
  sup_cause_t       cause_vec, cause_lat;

  assign async_in = {wd_strobe_i, mrst_n_i};

  sup_sync2 #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (async_in),
    .q_o  (sync_out)
  );

  assign mr_n_sync   = sync_out[0];
  assign strobe_sync = sync_out[1];

  sup_mr_filter #(.MR_GLITCH(MR_GLITCH)) u_mr (
    .clk        (clk),
    .rst_n      (rst_n),
    .mr_n_sync_i(mr_n_sync),
    .mr_active_o(mr_active)
  );

  sup_watchdog #(.WD_TIMEOUT(WD_TIMEOUT)) u_wd (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_sync_i(strobe_sync),
    .float_i      (wd_float_i),
    .hold_i       (rst_asserted),
    .expire_o     (wd_expire),
    .cnt_o        (wd_cnt)
  );

  always_comb begin
    cause_vec.supply = supply_fault_i;
    cause_vec.manual = mr_active;
    cause_vec.wdog   = wd_expire;
  end

  sup_hold_timer #(.RST_TIMEOUT(RST_TIMEOUT)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cause_i   (cause_vec),
    .asserted_o(rst_asserted),
    .cause_o   (cause_lat)
  );

  assign reset_n_o = ~rst_asserted;
  assign cause_o   = cause_lat;

endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_fault_i,
  input logic             wd_float_i,
  input logic             reset_n_o,
  input logic [2:0]       cause_o,
  input logic [2:0]       cause_now,
  input logic             mr_active,
  input logic             wd_expire,
  input logic [CNT_W-1:0] wd_cnt
);

  AST_FAULT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fault_i |=> !reset_n_o); // R2

  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n_o) |-> ($past(cause_now) == 3'b000)); // R2

  AST_MANUAL_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    mr_active |=> !reset_n_o); // R3

  AST_WD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_n_o |=> (wd_cnt == '0)); // R7

  AST_FLOAT_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_float_i |-> !wd_expire); // R8

  AST_EXPIRE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> cause_o[2]); // R9

  AST_CAUSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_n_o && $past(reset_n_o)) |-> $stable(cause_o)); // R9

endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(.CNT_W(WD_CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_fault_i(supply_fault_i),
  .wd_float_i    (wd_float_i),
  .reset_n_o     (reset_n_o),
  .cause_o       (cause_o),
  .cause_now     (cause_vec),
  .mr_active     (mr_active),
  .wd_expire     (wd_expire),
  .wd_cnt        (wd_cnt)
);

// File: tb/sup_reset_ctrl_bench.sv
`timescale 1ns/1ps
module sup_reset_ctrl_bench;

  localparam int RT  = 16;
  localparam int WD  = 64;
  localparam int MRG = 8;

  logic       clk;
  logic       rst_n;
  logic       supply_fault_i;
  logic       mrst_n_i;
  logic       wd_strobe_i;
  logic       wd_float_i;
  logic       reset_n_o;
  logic [2:0] cause_o;

  int n_checks;
  int n_fail;
  bit done;

  sup_reset_ctrl #(.RST_TIMEOUT(RT), .WD_TIMEOUT(WD), .MR_GLITCH(MRG)) u_sup_reset_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_fault_i(supply_fault_i),
    .mrst_n_i      (mrst_n_i),
    .wd_strobe_i   (wd_strobe_i),
    .wd_float_i    (wd_float_i),
    .reset_n_o     (reset_n_o),
    .cause_o       (cause_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Counts consecutive negedge samples of reset_n_o equal to lvl, current one included.
  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (reset_n_o == lvl && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_power_on;
    int n;
    rst_n = 1'b0;
    supply_fault_i = 1'b0;
    mrst_n_i = 1'b1;
    wd_strobe_i = 1'b0;
    wd_float_i = 1'b1;
    repeat (3) @(negedge clk);
    check(reset_n_o == 1'b0, "R1 reset low during rst_n", reset_n_o, 0);
    check(cause_o == 3'b000, "R1 cause cleared", cause_o, 0);
    rst_n = 1'b1;
    count_level(1'b0, n);
    check(n == RT, "R1 power-on hold length", n, RT);
  endtask

  task automatic t_supply(input int hold_cycles);
    int n;
    supply_fault_i = 1'b1;
    @(negedge clk);
    check(reset_n_o == 1'b0, "R2 fault asserts next edge", reset_n_o, 0);
    repeat (hold_cycles) @(negedge clk);
    supply_fault_i = 1'b0;
    count_level(1'b0, n);
    check(n == RT, "R2 hold after fault", n, RT);
    check(cause_o == 3'b001, "R9 supply cause", cause_o, 1);
  endtask

  task automatic t_mr_short;
    int bad;
    bad = 0;
    mrst_n_i = 1'b0;
    repeat (MRG - 4) @(negedge clk);
    mrst_n_i = 1'b1;
    repeat (3 * RT) begin
      @(negedge clk);
      if (!reset_n_o) bad++;
    end
    check(bad == 0, "R4 short manual pulse ignored", bad, 0);
  endtask

  task automatic t_mr_long;
    int n;
    mrst_n_i = 1'b0;
    repeat (MRG + 6) @(negedge clk);
    check(reset_n_o == 1'b0, "R3 long manual low asserts", reset_n_o, 0);
    mrst_n_i = 1'b1;
    count_level(1'b0, n);
    check(n == RT + 3, "R3 release delay after manual", n, RT + 3);
    check(cause_o == 3'b010, "R9 manual cause", cause_o, 2);
  endtask

  task automatic t_wd_expire;
    int n;
    wd_float_i = 1'b0;
    supply_fault_i = 1'b1;
    @(negedge clk);
    supply_fault_i = 1'b0;
    count_level(1'b0, n);
    check(n == RT, "R2 single-cycle fault hold", n, RT);
    count_level(1'b1, n);
    check(n == WD, "R5 R7 watchdog high time from release", n, WD);
    count_level(1'b0, n);
    check(n == RT, "R5 watchdog reset length", n, RT);
    wd_float_i = 1'b1;
    check(cause_o == 3'b100, "R9 watchdog cause", cause_o, 4);
  endtask

  task automatic t_wd_strobe;
    int bad;
    bad = 0;
    wd_float_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      repeat (WD / 2) begin
        @(negedge clk);
        if (!reset_n_o) bad++;
      end
      wd_strobe_i = ~wd_strobe_i;
    end
    check(bad == 0, "R6 level toggles keep reset high", bad, 0);
    bad = 0;
    wd_strobe_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      repeat (WD - 10) begin
        @(negedge clk);
        if (!reset_n_o) bad++;
      end
      wd_strobe_i = 1'b1;
      @(negedge clk);
      if (!reset_n_o) bad++;
      wd_strobe_i = 1'b0;
    end
    check(bad == 0, "R6 single-cycle pulses keep reset high", bad, 0);
    wd_float_i = 1'b1;
  endtask

  task automatic t_wd_float;
    int bad;
    bad = 0;
    wd_float_i = 1'b1;
    repeat (6 * WD) begin
      @(negedge clk);
      if (!reset_n_o) bad++;
    end
    check(bad == 0, "R8 floating strobe never expires", bad, 0);
    check(cause_o == 3'b100, "R9 cause stable while released", cause_o, 4);
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    done = 1'b0;
    t_power_on();
    t_supply(4);
    t_mr_short();
    t_mr_long();
    t_wd_expire();
    t_wd_strobe();
    t_wd_float();
    t_supply(1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule